// File: doc/BRIEF.md
# H-Bridge Phase Interlock

This block sequences the four switches of one full bridge driving a motor winding. Leg A and leg B each have a high-side (source) switch and a low-side (sink) switch. A phase input chooses the current direction, a halt input turns the whole bridge off, and a chopper drive-on signal from a current regulator pulses the active low-side switch.

Every switch change is timed by counters. Releasing a switch uses an off-delay, and closing a switch uses an on-delay. Each delay is a separate parameter in clock cycles, set apart for the high side and the low side. A direction change has one set of delays and a halt change has another. A switch also never closes while the other switch on its own leg is still closed. The defaults assume a 1 MHz clock, with fractional microseconds rounded up.

Top module: `hbridge_interlock`

## Requirements
- R1: With halt low and the delays elapsed, phase = 1 closes leg A high side and leg B low side, and phase = 0 closes leg B high side and leg A low side. Output bit order used in checks is {aHighOn, aLowOn, bHighOn, bLowOn}, so these states read 1001 and 0110. The two high sides are never on together, and neither are the two low sides.
- R2: While halt is high, every switch is open and no high side closes, whatever phase does.
- R3: A phase change is counted from the first rising clock edge that samples it, called edge 0. On a phase change the old low side opens at edge PH_LO_OFF (default 2) and the old high side opens at edge PH_HI_OFF (default 3). The new high side closes at edge PH_HI_ON (default 9) and the new low side closes at edge PH_LO_ON (default 10).
- R4: A halt change is counted from the edge that samples it. When halt goes low, both active switches close at edge HT_ON (default 9). When halt goes high, the low side opens at edge HT_LO_OFF (default 2) and the high side opens at edge HT_HI_OFF (default 7).
- R5: The high side and the low side of the same leg are never on together.
- R6: Each low-side output is its switch state ANDed with chopOn, with no clock delay. chopOn has no effect on the high sides.
- R7: A new phase or halt request restarts the delay count at its own sampling edge. A switch that is already in the state the new request asks for stays there with no glitch. A switch that must close waits the full on-delay, counted from the newest request.
- R8: An asynchronous active-low reset opens all four switches at once. The block then starts as halted with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseIn | input | 1 | Direction: 1 drives leg A high, 0 drives leg B high |
| haltIn | input | 1 | 1 opens every switch, 0 lets the bridge drive |
| chopOn | input | 1 | Chopper drive-on, gates the active low side |
| aHighOn | output | 1 | Leg A high-side switch on |
| aLowOn | output | 1 | Leg A low-side switch on |
| bHighOn | output | 1 | Leg B high-side switch on |
| bLowOn | output | 1 | Leg B low-side switch on |

## Verification
The bench samples the outputs one cycle before and one cycle after each programmed delay. A design that counts from the wrong edge, or that swaps the high-side and low-side values, therefore misses the exact cycle. The bench also issues a reversal that arrives after the old low side has opened but before the old high side has. A design that restarts badly either opens the high side that should stay closed, or closes the low side before a fresh on-delay has run. Two further cases catch a design that trusts the phase input alone: a phase change while halted, and a halt release that follows it, which must use the halt on-delay rather than the phase on-delay. A monitor watches every cycle for both switches of one leg closed at once.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;
  // Strobes from the timing control to the switch datapath
  typedef struct packed {
    logic phaseT;   // held direction request
    logic haltT;    // held halt request
    logic hiOffOk;  // high-side off-delay reached
    logic loOffOk;  // low-side off-delay reached
    logic hiOnOk;   // high-side on-delay reached
    logic loOnOk;   // low-side on-delay reached
  } hbiStrobe_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hbi_ctrl.sv
`timescale 1ns/1ps
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter int PH_HI_ON  = 9,
  parameter int PH_LO_ON  = 10,
  parameter int PH_HI_OFF = 3,
  parameter int PH_LO_OFF = 2,
  parameter int HT_ON     = 9,
  parameter int HT_HI_OFF = 7,
  parameter int HT_LO_OFF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseIn,
  input  logic       haltIn,
  output hbiStrobe_t strobe
);
  localparam int MAXD = maxOf(maxOf(maxOf(PH_HI_ON, PH_LO_ON), maxOf(PH_HI_OFF, PH_LO_OFF)),
                              maxOf(HT_ON, maxOf(HT_HI_OFF, HT_LO_OFF)));
  localparam int CW = $clog2(MAXD + 1);
  localparam logic [CW-1:0] SAT = CW'(MAXD);

  logic          phaseQ, haltQ, haltMode;
  logic [CW-1:0] elapsed;
  logic          newReq;

  assign newReq = (phaseIn != phaseQ) || (haltIn != haltQ);

  // elapsed counts edges since the sampling edge of the last request (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= 1'b0;
      haltQ    <= 1'b1;
      haltMode <= 1'b1;
      elapsed  <= SAT;
    end else begin
      phaseQ <= phaseIn;
      haltQ  <= haltIn;
      if (newReq) begin
        elapsed  <= CW'(1);
        haltMode <= (haltIn != haltQ);
      end else if (elapsed != SAT) begin
        elapsed <= elapsed + CW'(1);
      end
    end
  end

  always_comb begin
    strobe.phaseT  = phaseQ;
    strobe.haltT   = haltQ;
    strobe.hiOffOk = elapsed >= (haltMode ? CW'(HT_HI_OFF) : CW'(PH_HI_OFF));
    strobe.loOffOk = elapsed >= (haltMode ? CW'(HT_LO_OFF) : CW'(PH_LO_OFF));
    strobe.hiOnOk  = elapsed >= (haltMode ? CW'(HT_ON)     : CW'(PH_HI_ON));
    strobe.loOnOk  = elapsed >= (haltMode ? CW'(HT_ON)     : CW'(PH_LO_ON));
  end
endmodule

// File: rtl/hbi_switches.sv
`timescale 1ns/1ps
module hbi_switches
  import hbi_pkg::*;
#(
  parameter int LEGS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  hbiStrobe_t      strobe,
  input  logic            chopOn,
  output logic [LEGS-1:0] highOn,
  output logic [LEGS-1:0] lowOn
);
  logic [LEGS-1:0] hiQ, loQ;

  for (genvar leg = 0; leg < LEGS; leg++) begin : g_leg
    // leg 0 is driven high when phase is 1, the other leg when phase is 0
    localparam logic HI_PHASE = (leg == 0);
    logic hiWant, loWant;
    assign hiWant = !strobe.haltT && (strobe.phaseT == HI_PHASE);
    assign loWant = !strobe.haltT && (strobe.phaseT != HI_PHASE);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ[leg] <= 1'b0;
        loQ[leg] <= 1'b0;
      end else begin
        if (hiQ[leg] && !hiWant && strobe.hiOffOk)
          hiQ[leg] <= 1'b0;
        else if (!hiQ[leg] && hiWant && strobe.hiOnOk && !loQ[leg])
          hiQ[leg] <= 1'b1;
        if (loQ[leg] && !loWant && strobe.loOffOk)
          loQ[leg] <= 1'b0;
        else if (!loQ[leg] && loWant && strobe.loOnOk && !hiQ[leg])
          loQ[leg] <= 1'b1;
      end
    end

    assign highOn[leg] = hiQ[leg];
    assign lowOn[leg]  = loQ[leg] && chopOn;
  end
endmodule

// File: rtl/hbridge_interlock.sv
`timescale 1ns/1ps
module hbridge_interlock
  import hbi_pkg::*;
#(
  parameter int PH_HI_ON  = 9,
  parameter int PH_LO_ON  = 10,
  parameter int PH_HI_OFF = 3,
  parameter int PH_LO_OFF = 2,
  parameter int HT_ON     = 9,
  parameter int HT_HI_OFF = 7,
  parameter int HT_LO_OFF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic phaseIn,
  input  logic haltIn,
  input  logic chopOn,
  output logic aHighOn,
  output logic aLowOn,
  output logic bHighOn,
  output logic bLowOn
);
  hbiStrobe_t strobe;
  logic [1:0] highOn, lowOn;

  hbi_ctrl #(
    .PH_HI_ON(PH_HI_ON), .PH_LO_ON(PH_LO_ON), .PH_HI_OFF(PH_HI_OFF), .PH_LO_OFF(PH_LO_OFF),
    .HT_ON(HT_ON), .HT_HI_OFF(HT_HI_OFF), .HT_LO_OFF(HT_LO_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .haltIn(haltIn), .strobe(strobe)
  );

  hbi_switches #(.LEGS(2)) u_sw (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chopOn(chopOn),
    .highOn(highOn), .lowOn(lowOn)
  );

  assign aHighOn = highOn[0];
  assign aLowOn  = lowOn[0];
  assign bHighOn = highOn[1];
  assign bLowOn  = lowOn[1];
endmodule

// File: rtl/hbi_checker.sv
`timescale 1ns/1ps
module hbi_checker (
  input logic clk,
  input logic rstN,
  input logic phaseIn,
  input logic haltIn,
  input logic chopOn,
  input logic aHighOn,
  input logic aLowOn,
  input logic bHighOn,
  input logic bLowOn
);
  p_leg_a_excl_r5: assert property (@(posedge clk) disable iff (!rstN) !(aHighOn && aLowOn));
  p_leg_b_excl_r5: assert property (@(posedge clk) disable iff (!rstN) !(bHighOn && bLowOn));
  p_high_excl_r1:  assert property (@(posedge clk) disable iff (!rstN) !(aHighOn && bHighOn));
  p_low_excl_r1:   assert property (@(posedge clk) disable iff (!rstN) !(aLowOn && bLowOn));
  p_halt_hold_r2:  assert property (@(posedge clk) disable iff (!rstN)
                     $past(haltIn, 2) |-> (!$rose(aHighOn) && !$rose(bHighOn)));
  p_a_chop_r6:     assert property (@(posedge clk) disable iff (!rstN) $rose(aLowOn) |-> chopOn);
  p_b_chop_r6:     assert property (@(posedge clk) disable iff (!rstN) $rose(bLowOn) |-> chopOn);
endmodule

bind hbridge_interlock hbi_checker u_chk (
  .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .haltIn(haltIn), .chopOn(chopOn),
  .aHighOn(aHighOn), .aLowOn(aLowOn), .bHighOn(bHighOn), .bLowOn(bLowOn)
);

// File: tb/sim_hbridge_interlock.sv
`timescale 1ns/1ps
module sim_hbridge_interlock;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseIn = 1'b1, haltIn = 1'b1, chopOn = 1'b1;
  logic aHighOn, aLowOn, bHighOn, bLowOn;
  int checks = 0, errors = 0, shootCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbridge_interlock u0 (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .haltIn(haltIn), .chopOn(chopOn),
    .aHighOn(aHighOn), .aLowOn(aLowOn), .bHighOn(bHighOn), .bLowOn(bLowOn)
  );

  // row: {phase, halt, chop, edges[4:0], expect{aH,aL,bH,bL}, req[3:0]}
  localparam int ROWS = 22;
  localparam logic [15:0] VEC [ROWS] = '{
    {3'b111, 5'd3,  4'b0000, 4'd2}, // R2 halted, all open
    {3'b101, 5'd9,  4'b0000, 4'd4}, // R4 release, edge 8 still open
    {3'b101, 5'd1,  4'b1001, 4'd1}, // R1 edge 9 closes A high + B low
    {3'b100, 5'd1,  4'b1000, 4'd6}, // R6 chop off hides B low
    {3'b101, 5'd1,  4'b1001, 4'd6}, // R6 chop back
    {3'b001, 5'd2,  4'b1001, 4'd3}, // R3 reverse, edge 1 unchanged
    {3'b001, 5'd1,  4'b1000, 4'd3}, // R3 low opens at edge 2
    {3'b001, 5'd1,  4'b0000, 4'd3}, // R3 high opens at edge 3
    {3'b001, 5'd5,  4'b0000, 4'd3}, // R3 edge 8 still open
    {3'b001, 5'd1,  4'b0010, 4'd3}, // R3 high closes at edge 9
    {3'b001, 5'd1,  4'b0110, 4'd1}, // R1 low closes at edge 10
    {3'b101, 5'd2,  4'b0110, 4'd7}, // R7 reverse again
    {3'b001, 5'd1,  4'b0010, 4'd7}, // R7 restart after low opened
    {3'b001, 5'd9,  4'b0010, 4'd7}, // R7 B high held, A low waits
    {3'b001, 5'd1,  4'b0110, 4'd7}, // R7 A low closes 10 after restart
    {3'b011, 5'd2,  4'b0110, 4'd4}, // R4 halt, edge 1 unchanged
    {3'b011, 5'd1,  4'b0010, 4'd4}, // R4 low opens at edge 2
    {3'b011, 5'd4,  4'b0010, 4'd4}, // R4 edge 6 high still on
    {3'b011, 5'd1,  4'b0000, 4'd2}, // R2 high opens at edge 7
    {3'b111, 5'd12, 4'b0000, 4'd2}, // R2 phase change while halted
    {3'b101, 5'd9,  4'b0000, 4'd4}, // R4 release uses halt on-delay
    {3'b101, 5'd1,  4'b1001, 4'd4}  // R4 closes at edge 9
  };

  task automatic check(input logic [3:0] expv, input int req);
    logic [3:0] act;
    act = {aHighOn, aLowOn, bHighOn, bLowOn};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d: outputs %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  // R5 monitor: both switches of one leg closed together
  always @(negedge clk)
    if (rstN && ((aHighOn && aLowOn) || (bHighOn && bLowOn))) shootCount++;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(4'b0000, 8); // R8 reset state
    for (int i = 0; i < ROWS; i++) begin
      {phaseIn, haltIn, chopOn} = VEC[i][15:13];
      repeat (int'(VEC[i][12:8])) @(posedge clk);
      @(negedge clk);
      check(VEC[i][7:4], int'(VEC[i][3:0]));
    end
    // R8 asynchronous reset while driving
    rstN = 1'b0;
    #1;
    check(4'b0000, 8);
    // R5 leg exclusion over the whole run
    checks++;
    if (shootCount != 0) begin
      errors++;
      $display("FAIL R5: shoot-through cycles %0d expected 0", shootCount);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule